// File: doc/BRIEF.md
# SDRAM Read Latency Pipeline

This block models the command side and the data-out timing of a single-bank synchronous DRAM. On every rising clock edge it samples a command and keeps a record of whether the bank is idle or has a row open. It also holds a small mode word with the burst length, the burst order and the read latency. For each accepted read it produces a stream of column addresses, one per cycle. It delays that stream by the programmed latency and presents it on an output with a valid strobe. The memory array and its contents are not modelled.

The block accepts a new command on every cycle, even while the data of earlier reads is still in flight. A read, write, terminate or precharge stops further beats of the current burst at the cycle it is sampled. Beats that were already generated still come out after their latency, so a newer read cuts the older burst off at the right point on the output. A command that is not allowed in the current bank state raises a one-cycle flag and has no other effect. A read or write with the auto-close bit set closes the bank by itself once its burst is done.

Top module: `sdram_rdpipe`

## Requirements
- R1: After reset no data is valid, no flag is raised and the bank is idle. The mode is burst length 1, sequential order and read latency 2.
- R2: The first beat of a read appears on the output exactly CL clock edges after the edge that samples the read, for CL = 1, 2 and 3.
- R3: The mode burst code is addr_i[2:0]. Codes 0, 1, 2 and 3 give 1, 2, 4 and 8 beats, and these beats come on consecutive cycles.
- R4: With addr_i[3]=0 at mode load (sequential order), beat i carries column base + ((start + i) mod BL). Here base is the start column with its low log2(BL) bits cleared, so the order wraps within the aligned block.
- R5: With addr_i[3]=1 (interleaved order), beat i carries column base + ((start mod BL) XOR i).
- R6: A command is accepted on every cycle. A read sampled while an earlier burst is still being generated ends that burst at once, and the new burst follows on the output with no gap and no overlap.
- R7: Burst terminate (code 4) and write (code 3) stop the generation of further read beats. So does precharge (code 5), which also closes the bank. Beats already generated still appear.
- R8: While the bank is open, activate (1), auto refresh (6) and mode load (7) raise illegal_o on the next cycle only and change nothing.
- R9: While the bank is idle, read (2), write (3), terminate (4) and precharge (5) raise illegal_o and produce no data. NOP (0) is legal in every state.
- R10: Mode load (7) is legal only when the latency field addr_i[6:4] is 1 to 3 and the burst code is 0 to 3. Any other value raises illegal_o and leaves the mode unchanged.
- R11: A read with ap_i=1 sampled on edge e closes the bank after the edge e+CL+BL. Every command except NOP up to and including that edge is illegal, and an activate on edge e+CL+BL+1 is legal.
- R12: A write with ap_i=1 sampled on edge e closes the bank after the edge e+BL. Non-NOP commands up to that edge are illegal, activate is legal on edge e+BL+1, and the write produces no read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all commands are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 3 | Command code: 0 NOP, 1 activate, 2 read, 3 write, 4 terminate, 5 precharge, 6 refresh, 7 mode load |
| addr_i | input | COL_W | Row on activate, start column on read/write, mode word on mode load |
| ap_i | input | 1 | Auto-close request on read and write |
| rd_valid_o | output | 1 | A read beat is on rd_col_o this cycle |
| rd_col_o | output | COL_W | Column of the current read beat |
| illegal_o | output | 1 | Previous command was illegal and ignored |

## Verification
The latency assertions take for granted that the latency field does not change while beats are still in flight. A mode load is legal only with the bank idle, but a precharge can leave beats in the delay line. The stimulus therefore waits until each read has fully drained before it closes the bank and loads a new mode. The sweep covers every legal latency, burst code and order with eight start columns each. Directed sequences then cover truncation, the stopping commands, the auto-close windows and the illegal cases.

// File: rtl/sdram_rdpipe_pkg.sv
package sdram_rdpipe_pkg;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_BST  = 3'd4,
    CMD_PRE  = 3'd5,
    CMD_REF  = 3'd6,
    CMD_LMR  = 3'd7
  } cmd_e;

  localparam int MODE_CL_W = 3;
  localparam int MODE_BL_W = 3;

  // Bit positions of the mode word on addr_i
  localparam int MODE_BL_LSB  = 0;
  localparam int MODE_ILV_BIT = 3;
  localparam int MODE_CL_LSB  = 4;
  localparam int MODE_TOP_BIT = MODE_CL_LSB + MODE_CL_W - 1;

  typedef struct packed {
    logic [MODE_CL_W-1:0] cl;
    logic                 ilv;
    logic [MODE_BL_W-1:0] blog2;
  } mode_t;

endpackage

// File: rtl/sdram_cmd_ctrl.sv
module sdram_cmd_ctrl
  import sdram_rdpipe_pkg::*;
#(
  parameter int COL_W     = 8,
  parameter int MAX_CL    = 3,
  parameter int MAX_BLOG2 = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       cmd_i,
  input  logic [COL_W-1:0] addr_i,
  input  logic             ap_i,
  output logic             start_rd_o,
  output logic             start_wr_o,
  output logic             stop_o,
  output mode_t            mode_o,
  output logic             illegal_o,
  output logic             bank_open_o,
  output logic             closing_o
);

  localparam int CNT_W = $clog2(MAX_CL + (1 << MAX_BLOG2) + 1);

  logic             open_q, open_d;
  logic             closing_q, closing_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ill_q, ill_d;
  mode_t            mode_q, mode_new;
  logic             mode_we;
  logic             mode_bad;
  logic [CNT_W-1:0] blen;
  logic             busy;

  assign mode_new.cl    = addr_i[MODE_CL_LSB +: MODE_CL_W];
  assign mode_new.ilv   = addr_i[MODE_ILV_BIT];
  assign mode_new.blog2 = addr_i[MODE_BL_LSB +: MODE_BL_W];

  assign mode_bad = (int'(mode_new.blog2) > MAX_BLOG2) ||
                    (mode_new.cl == '0) ||
                    (int'(mode_new.cl) > MAX_CL);

  assign blen = CNT_W'(1) << mode_q.blog2;
  assign busy = !open_q || closing_q;

  always_comb begin
    open_d     = open_q;
    closing_d  = closing_q;
    cnt_d      = cnt_q;
    ill_d      = 1'b0;
    mode_we    = 1'b0;
    start_rd_o = 1'b0;
    start_wr_o = 1'b0;
    stop_o     = 1'b0;

    if (closing_q) begin
      cnt_d = cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) begin
        open_d    = 1'b0;
        closing_d = 1'b0;
      end
    end

    unique case (cmd_e'(cmd_i))
      CMD_NOP: ;
      CMD_ACT: begin
        if (open_q) ill_d = 1'b1;
        else        open_d = 1'b1;
      end
      CMD_RD, CMD_WR: begin
        if (busy) begin
          ill_d = 1'b1;
        end else begin
          start_rd_o = (cmd_i == CMD_RD);
          start_wr_o = (cmd_i == CMD_WR);
          if (ap_i) begin
            closing_d = 1'b1;
            cnt_d     = (cmd_i == CMD_RD) ? (CNT_W'(mode_q.cl) + blen) : blen;
          end
        end
      end
      CMD_BST: begin
        if (busy) ill_d = 1'b1;
        else      stop_o = 1'b1;
      end
      CMD_PRE: begin
        if (busy) begin
          ill_d = 1'b1;
        end else begin
          stop_o = 1'b1;
          open_d = 1'b0;
        end
      end
      CMD_REF: begin
        if (open_q) ill_d = 1'b1;
      end
      CMD_LMR: begin
        if (open_q || mode_bad) ill_d = 1'b1;
        else                    mode_we = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q    <= 1'b0;
      closing_q <= 1'b0;
      cnt_q     <= '0;
      ill_q     <= 1'b0;
    end else begin
      open_q    <= open_d;
      closing_q <= closing_d;
      cnt_q     <= cnt_d;
      ill_q     <= ill_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q.cl    <= MODE_CL_W'(2);
      mode_q.ilv   <= 1'b0;
      mode_q.blog2 <= '0;
    end else if (mode_we) begin
      mode_q <= mode_new;
    end
  end

  assign mode_o      = mode_q;
  assign illegal_o   = ill_q;
  assign bank_open_o = open_q;
  assign closing_o   = closing_q;

endmodule

// File: rtl/sdram_burst_gen.sv
module sdram_burst_gen
  import sdram_rdpipe_pkg::*;
#(
  parameter int COL_W     = 8,
  parameter int MAX_BLOG2 = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_rd_i,
  input  logic             start_wr_i,
  input  logic             stop_i,
  input  logic [COL_W-1:0] col_i,
  input  mode_t            mode_i,
  output logic             beat_valid_o,
  output logic [COL_W-1:0] beat_col_o
);

  localparam int IDX_W = (MAX_BLOG2 < 1) ? 1 : MAX_BLOG2;

  logic             act_q, act_d;
  logic             rd_q;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [COL_W-1:0] start_q;
  logic [MODE_BL_W-1:0] blog_q;
  logic             ilv_q;
  logic             load;

  function automatic logic [COL_W-1:0] order_col(
    input logic [COL_W-1:0]     start,
    input logic [IDX_W-1:0]     idx,
    input logic [MODE_BL_W-1:0] blog2,
    input logic                 ilv
  );
    logic [COL_W-1:0] mask;
    logic [COL_W-1:0] low;
    mask = (COL_W'(1) << blog2) - COL_W'(1);
    low  = ilv ? (start ^ COL_W'(idx)) : (start + COL_W'(idx));
    return (start & ~mask) | (low & mask);
  endfunction

  function automatic logic is_last(
    input logic [IDX_W-1:0]     idx,
    input logic [MODE_BL_W-1:0] blog2
  );
    return idx == IDX_W'((32'd1 << blog2) - 32'd1);
  endfunction

  assign load = start_rd_i || start_wr_i;

  always_comb begin
    act_d        = act_q;
    idx_d        = idx_q;
    beat_valid_o = 1'b0;
    beat_col_o   = '0;
    if (load) begin
      beat_valid_o = start_rd_i;
      beat_col_o   = col_i;
      act_d        = !is_last('0, mode_i.blog2);
      idx_d        = IDX_W'(1);
    end else if (stop_i) begin
      act_d = 1'b0;
    end else if (act_q) begin
      beat_valid_o = rd_q;
      beat_col_o   = order_col(start_q, idx_q, blog_q, ilv_q);
      act_d        = !is_last(idx_q, blog_q);
      idx_d        = idx_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      idx_q <= '0;
    end else begin
      act_q <= act_d;
      idx_q <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q    <= 1'b0;
      start_q <= '0;
      blog_q  <= '0;
      ilv_q   <= 1'b0;
    end else if (load) begin
      rd_q    <= start_rd_i;
      start_q <= col_i;
      blog_q  <= mode_i.blog2;
      ilv_q   <= mode_i.ilv;
    end
  end

endmodule

// File: rtl/sdram_lat_line.sv
module sdram_lat_line
  import sdram_rdpipe_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int MAX_CL = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 beat_valid_i,
  input  logic [COL_W-1:0]     beat_col_i,
  input  logic [MODE_CL_W-1:0] cl_i,
  output logic                 rd_valid_o,
  output logic [COL_W-1:0]     rd_col_o
);

  logic             v_q [MAX_CL+1];
  logic [COL_W-1:0] c_q [MAX_CL+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q[0] <= 1'b0;
      c_q[0] <= '0;
    end else begin
      v_q[0] <= beat_valid_i;
      c_q[0] <= beat_col_i;
    end
  end

  for (genvar s = 1; s <= MAX_CL; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q[s] <= 1'b0;
        c_q[s] <= '0;
      end else begin
        v_q[s] <= v_q[s-1];
        c_q[s] <= c_q[s-1];
      end
    end
  end

  always_comb begin
    rd_valid_o = 1'b0;
    rd_col_o   = '0;
    for (int s = 1; s <= MAX_CL; s++) begin
      if (int'(cl_i) == s) begin
        rd_valid_o = v_q[s];
        rd_col_o   = c_q[s];
      end
    end
  end

endmodule

// File: rtl/sdram_rdpipe.sv
module sdram_rdpipe
  import sdram_rdpipe_pkg::*;
#(
  parameter int COL_W     = 8,
  parameter int MAX_CL    = 3,
  parameter int MAX_BLOG2 = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       cmd_i,
  input  logic [COL_W-1:0] addr_i,
  input  logic             ap_i,
  output logic             rd_valid_o,
  output logic [COL_W-1:0] rd_col_o,
  output logic             illegal_o
);

  logic             start_rd;
  logic             start_wr;
  logic             stop;
  mode_t            mode;
  logic             bank_open;
  logic             closing;
  logic             beat_valid;
  logic [COL_W-1:0] beat_col;

  sdram_cmd_ctrl #(
    .COL_W(COL_W), .MAX_CL(MAX_CL), .MAX_BLOG2(MAX_BLOG2)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .addr_i(addr_i), .ap_i(ap_i),
    .start_rd_o(start_rd), .start_wr_o(start_wr), .stop_o(stop),
    .mode_o(mode), .illegal_o(illegal_o),
    .bank_open_o(bank_open), .closing_o(closing)
  );

  sdram_burst_gen #(
    .COL_W(COL_W), .MAX_BLOG2(MAX_BLOG2)
  ) u_gen (
    .clk(clk), .rst_n(rst_n),
    .start_rd_i(start_rd), .start_wr_i(start_wr), .stop_i(stop),
    .col_i(addr_i), .mode_i(mode),
    .beat_valid_o(beat_valid), .beat_col_o(beat_col)
  );

  sdram_lat_line #(
    .COL_W(COL_W), .MAX_CL(MAX_CL)
  ) u_line (
    .clk(clk), .rst_n(rst_n),
    .beat_valid_i(beat_valid), .beat_col_i(beat_col), .cl_i(mode.cl),
    .rd_valid_o(rd_valid_o), .rd_col_o(rd_col_o)
  );

endmodule

// File: rtl/sdram_rdpipe_chk.sv
module sdram_rdpipe_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] cmd_i,
  input logic       illegal_o,
  input logic       rd_valid_o,
  input logic       bank_open,
  input logic       closing,
  input logic       beat_valid,
  input logic [2:0] cl
);

  AST_NOP_NEVER_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == 3'd0) |=> !illegal_o); // R9

  AST_ACT_OPEN_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == 3'd1 && bank_open) |=> illegal_o); // R8

  AST_READ_IDLE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == 3'd2 && !bank_open) |=> illegal_o); // R9

  AST_NO_BEAT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_open |-> !beat_valid); // R9

  AST_PRE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == 3'd5 && bank_open && !closing) |=> !bank_open); // R7

  AST_CL1_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && cl == 3'd1) |=> ##1 rd_valid_o); // R2

  AST_CL2_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && cl == 3'd2) |=> ##2 rd_valid_o); // R2

  AST_CL3_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && cl == 3'd3) |=> ##3 rd_valid_o); // R2

endmodule

bind sdram_rdpipe sdram_rdpipe_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .illegal_o(illegal_o),
  .rd_valid_o(rd_valid_o), .bank_open(bank_open), .closing(closing),
  .beat_valid(beat_valid), .cl(mode.cl)
);

// File: tb/sdram_rdpipe_tb.sv
module sdram_rdpipe_tb;

  localparam int CLK_PERIOD = 10;

  localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3,
                         BST = 3'd4, PRE = 3'd5, REF = 3'd6, LMR = 3'd7;

  logic       clk;
  logic       rst_n;
  logic [2:0] cmd;
  logic [7:0] addr;
  logic       ap;
  logic       rd_valid_o;
  logic [7:0] rd_col_o;
  logic       illegal_o;

  int n_chk;
  int n_fail;
  bit done;

  sdram_rdpipe u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .addr_i(addr), .ap_i(ap),
    .rd_valid_o(rd_valid_o), .rd_col_o(rd_col_o), .illegal_o(illegal_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] mw(int cl, int ord, int blc);
    return 8'((cl << 4) | (ord << 3) | blc);
  endfunction

  function automatic logic [7:0] ecol(int start, int i, int bl, int ord);
    int base;
    int off;
    base = start - (start % bl);
    off  = start % bl;
    if (ord == 0) return 8'(base + ((off + i) % bl));
    return 8'(base + (off ^ i));
  endfunction

  task automatic expect_o(bit v, logic [7:0] col, bit ill, string tag);
    n_chk++;
    if (rd_valid_o !== v || (v && rd_col_o !== col) || illegal_o !== ill) begin
      n_fail++;
      $display("FAIL %s: got valid=%0b col=%0d illegal=%0b, expected valid=%0b col=%0d illegal=%0b",
               tag, rd_valid_o, rd_col_o, illegal_o, v, col, ill);
    end
  endtask

  task automatic step(logic [2:0] c, logic [7:0] a, logic p);
    cmd  = c;
    addr = a;
    ap   = p;
    @(posedge clk);
    @(negedge clk);
    cmd  = NOP;
    addr = '0;
    ap   = 1'b0;
  endtask

  // read with no overlap; k counts edges since the read was sampled
  task automatic run_read(int start, int cl, int blc, int ord);
    int bl;
    string tg;
    bl = 1 << blc;
    tg = $sformatf("R2 R3 %s cl=%0d bl=%0d start=%0d", (ord != 0) ? "R5" : "R4", cl, bl, start);
    step(RD, 8'(start), 1'b0);
    for (int k = 0; k <= cl + bl + 1; k++) begin
      if (k > 0) step(NOP, '0, 1'b0);
      if (k >= cl && k < cl + bl) expect_o(1'b1, ecol(start, k - cl, bl, ord), 1'b0, tg);
      else                        expect_o(1'b0, '0, 1'b0, tg);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    cmd = NOP; addr = '0; ap = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state and default mode (CL2, BL1, sequential)
    expect_o(1'b0, '0, 1'b0, "R1 reset outputs");
    step(RD, 8'd1, 1'b0);
    expect_o(1'b0, '0, 1'b1, "R1 bank idle after reset");
    step(ACT, 8'd0, 1'b0);
    expect_o(1'b0, '0, 1'b0, "R1 activate");
    step(RD, 8'd5, 1'b0);
    expect_o(1'b0, '0, 1'b0, "R1 k0");
    step(NOP, '0, 1'b0);
    expect_o(1'b0, '0, 1'b0, "R1 k1");
    step(NOP, '0, 1'b0);
    expect_o(1'b1, 8'd5, 1'b0, "R1 default CL2 k2");
    step(NOP, '0, 1'b0);
    expect_o(1'b0, '0, 1'b0, "R1 default BL1 k3");
    step(PRE, '0, 1'b0);
    expect_o(1'b0, '0, 1'b0, "R1 precharge");

    // R2 R3 R4 R5 sweep
    for (int cl = 1; cl <= 3; cl++) begin
      for (int blc = 0; blc <= 3; blc++) begin
        for (int ord = 0; ord <= 1; ord++) begin
          step(LMR, mw(cl, ord, blc), 1'b0);
          expect_o(1'b0, '0, 1'b0, "R10 legal mode load");
          step(ACT, 8'd0, 1'b0);
          for (int s = 0; s < 8; s++) run_read((s << 5) | (s ^ 3), cl, blc, ord);
          step(PRE, '0, 1'b0);
        end
      end
    end

    // R6: truncation, CL3 BL2, reads on k0 and k2
    step(LMR, mw(3, 0, 1), 1'b0);
    step(ACT, 8'd0, 1'b0);
    step(RD, 8'd0, 1'b0);            // k0
    step(NOP, '0, 1'b0);             // k1
    step(RD, 8'd4, 1'b0);            // k2
    expect_o(1'b0, '0, 1'b0, "R6 k2 second read accepted");
    step(NOP, '0, 1'b0);
    expect_o(1'b1, 8'd0, 1'b0, "R6 k3");
    step(NOP, '0, 1'b0);
    expect_o(1'b1, 8'd1, 1'b0, "R6 k4");
    step(NOP, '0, 1'b0);
    expect_o(1'b1, 8'd4, 1'b0, "R6 k5");
    step(NOP, '0, 1'b0);
    expect_o(1'b1, 8'd5, 1'b0, "R6 k6");
    step(NOP, '0, 1'b0);
    expect_o(1'b0, '0, 1'b0, "R6 k7");
    step(PRE, '0, 1'b0);

    // R6: BL4 older burst truncated after two beats
    step(LMR, mw(3, 0, 2), 1'b0);
    step(ACT, 8'd0, 1'b0);
    step(RD, 8'd0, 1'b0);
    step(NOP, '0, 1'b0);
    step(RD, 8'd8, 1'b0);
    step(NOP, '0, 1'b0);
    expect_o(1'b1, 8'd0, 1'b0, "R6 bl4 k3");
    step(NOP, '0, 1'b0);
    expect_o(1'b1, 8'd1, 1'b0, "R6 bl4 k4");
    for (int k = 5; k <= 8; k++) begin
      step(NOP, '0, 1'b0);
      expect_o(1'b1, 8'(8 + k - 5), 1'b0, "R6 bl4 new burst");
    end
    step(NOP, '0, 1'b0);
    expect_o(1'b0, '0, 1'b0, "R6 bl4 k9");

    // R7: terminate, write, precharge on k2
    for (int v = 0; v < 3; v++) begin
      logic [2:0] sc;
      sc = (v == 0) ? BST : ((v == 1) ? WR : PRE);
      step(RD, 8'd0, 1'b0);
      step(NOP, '0, 1'b0);
      step(sc, 8'd0, 1'b0);
      expect_o(1'b0, '0, 1'b0, "R7 stop accepted");
      step(NOP, '0, 1'b0);
      expect_o(1'b1, 8'd0, 1'b0, "R7 k3");
      step(NOP, '0, 1'b0);
      expect_o(1'b1, 8'd1, 1'b0, "R7 k4");
      step(NOP, '0, 1'b0);
      expect_o(1'b0, '0, 1'b0, "R7 k5 cut off");
      step(NOP, '0, 1'b0);
      expect_o(1'b0, '0, 1'b0, "R7 k6 cut off");
    end
    // after precharge the bank is idle
    step(BST, '0, 1'b0);
    expect_o(1'b0, '0, 1'b1, "R7 precharge closed bank");

    // R9: idle-state illegal commands
    step(RD, 8'd2, 1'b0);
    expect_o(1'b0, '0, 1'b1, "R9 read idle");
    step(WR, 8'd2, 1'b0);
    expect_o(1'b0, '0, 1'b1, "R9 write idle");
    step(PRE, '0, 1'b0);
    expect_o(1'b0, '0, 1'b1, "R9 precharge idle");
    for (int k = 0; k < 5; k++) begin
      step(NOP, '0, 1'b0);
      expect_o(1'b0, '0, 1'b0, "R9 no data and flag cleared");
    end
    step(REF, '0, 1'b0);
    expect_o(1'b0, '0, 1'b0, "R9 refresh idle legal");

    // R10: bad mode values ignored (mode stays CL3 BL4 seq)
    step(LMR, mw(3, 0, 4), 1'b0);
    expect_o(1'b0, '0, 1'b1, "R10 burst code 4");
    step(LMR, mw(0, 0, 1), 1'b0);
    expect_o(1'b0, '0, 1'b1, "R10 latency 0");
    step(LMR, mw(4, 1, 0), 1'b0);
    expect_o(1'b0, '0, 1'b1, "R10 latency 4");
    step(ACT, 8'd0, 1'b0);
    expect_o(1'b0, '0, 1'b0, "R10 activate");

    // R8: open-state illegal commands, mode not changed
    step(ACT, 8'd1, 1'b0);
    expect_o(1'b0, '0, 1'b1, "R8 activate open");
    step(NOP, '0, 1'b0);
    expect_o(1'b0, '0, 1'b0, "R8 flag one cycle");
    step(REF, '0, 1'b0);
    expect_o(1'b0, '0, 1'b1, "R8 refresh open");
    step(LMR, mw(1, 1, 0), 1'b0);
    expect_o(1'b0, '0, 1'b1, "R8 mode load open");
    run_read(6, 3, 2, 0);

    // R11: read with auto-close, CL2 BL4
    step(PRE, '0, 1'b0);
    step(LMR, mw(2, 0, 2), 1'b0);
    step(ACT, 8'd0, 1'b0);
    step(RD, 8'd0, 1'b1);                   // k0
    expect_o(1'b0, '0, 1'b0, "R11 k0");
    step(NOP, '0, 1'b0);
    expect_o(1'b0, '0, 1'b0, "R11 k1");
    step(RD, 8'd4, 1'b0);                   // k2 illegal while closing
    expect_o(1'b1, 8'd0, 1'b1, "R11 k2 read rejected");
    for (int k = 3; k <= 5; k++) begin
      step(NOP, '0, 1'b0);
      expect_o(1'b1, 8'(k - 2), 1'b0, "R11 burst continues");
    end
    step(ACT, 8'd0, 1'b0);                  // k6
    expect_o(1'b0, '0, 1'b1, "R11 k6 still closing");
    step(ACT, 8'd0, 1'b0);                  // k7
    expect_o(1'b0, '0, 1'b0, "R11 k7 closed");

    // R12: write with auto-close, BL4
    step(WR, 8'd0, 1'b1);                   // k0
    expect_o(1'b0, '0, 1'b0, "R12 k0");
    for (int k = 1; k <= 3; k++) begin
      step(NOP, '0, 1'b0);
      expect_o(1'b0, '0, 1'b0, "R12 no read data");
    end
    step(ACT, 8'd0, 1'b0);                  // k4
    expect_o(1'b0, '0, 1'b1, "R12 k4 still closing");
    step(ACT, 8'd0, 1'b0);                  // k5
    expect_o(1'b0, '0, 1'b0, "R12 k5 closed");
    for (int k = 0; k < 4; k++) begin
      step(NOP, '0, 1'b0);
      expect_o(1'b0, '0, 1'b0, "R12 write gives no data");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule